// File: doc/BRIEF.md
# ATA PIO Command Sequencer

This block is a hardware master for one ATA channel. It runs a complete single-sector programmed-I/O command against the drive's task-file registers, so that a host does not have to poll status or write registers itself. The host presents an operation code together with the command byte, the device byte, the feature byte, a 16-bit sector count and a 48-bit address, and pulses a start strobe. The sequencer then waits for the drive to be idle, loads the registers in a fixed order and issues the command. For a read-type command it streams the 256 data words of one sector to a sink. It ends every accepted operation with a one-cycle done or error pulse.

The drive side is a simple register port. A 4-bit address selects a register, with a byte write strobe and a read strobe. Reads return up to 16 bits, all of which are used when the data register is read. The same sequencer can also run the channel's soft-reset routine. All waits are counted in clock cycles from a ticks-per-millisecond parameter, so the same design runs at any clock rate.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `bus_wr`, `bus_rd` and `word_valid` are all low.
- R2: `done` and `error` are one-cycle pulses, and each accepted operation gives exactly one of them. A `start` that arrives while `busy` is high is ignored. It does not change the running operation, and it is not acted on afterwards.
- R3: Before it programs any register, the sequencer reads status (address 7, busy is bit 7) and waits for busy to clear. If busy stays set for longer than TIMEOUT_MS milliseconds, the operation ends with `error` and no register is written.
- R4: A command (op 0 = data-in, op 1 = non-data, op 3 = non-data) performs exactly 12 writes in this order:
  - device-control (address 4'hA) = 8'h0A, which sets bit 3 (always one) and bit 1 (interrupts off);
  - device (address 6);
  - feature (address 1);
  - sector count (address 2): count[15:8], then count[7:0];
  - address-low (address 3): lba[31:24], then lba[7:0];
  - address-mid (address 4): lba[39:32], then lba[15:8];
  - address-high (address 5): lba[47:40], then lba[23:16];
  - command (address 7).
- R5: The device register is read (address 6) before it is written. If bit 4 (drive select) of the new value differs from the value read, at least SETTLE_MS milliseconds pass between the device write and the next write. Otherwise the next write follows in the very next cycle.
- R6: For a data-in command, if the status read that first shows busy clear has data-request (bit 3) clear, the operation ends with `error` and no data word is read.
- R7: For a data-in command with data-request set, the sequencer reads the data register (address 0) 256 times in consecutive cycles. It presents each word on `word_data` with `word_valid` high, in the order read.
- R8: After the burst, status is read once more. If data-request is still set, the operation ends with `error`. Otherwise it ends with `done`.
- R9: A non-data command waits for busy to clear after the command write and then ends with `done` without reading the data register.
- R10: The soft-reset operation (op 2) waits 2 ms and then waits for not-busy. It writes device-control with 8'h0E (bits 3, 2 and 1) and holds it for at least 5 µs. It then writes 8'h0A, waits 2 ms, waits for not-busy and ends with `done`. It makes no other register writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when idle |
| op | input | 2 | 0 data-in, 1 or 3 non-data, 2 soft reset |
| command | input | 8 | Command byte |
| device | input | 8 | Device register value |
| feature | input | 8 | Feature register value |
| count | input | 16 | Sector count (high byte written first) |
| lba | input | 48 | Address bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| bus_addr | output | 4 | Register address; bit 3 selects the control block |
| bus_wr | output | 1 | Byte write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 16 | Read data, valid in the cycle of `bus_rd` |
| word_valid | output | 1 | A data word is presented |
| word_data | output | 16 | Data word to the sink |

## Verification
Commands are applied with the device byte equal to, and then different from, the value already in the device register. This tells the settle path from the back-to-back path. Address and count values with every byte distinct show whether each byte reaches its register and is placed in the right half of its pair. The drive model answers in three ways: data-request asserted and released normally, never asserted, or left asserted after the burst. These separate the success path from the two data-request failure checks. A drive held busy, a soft reset, and a second start issued during a burst cover the timeout, the reset write sequence and the rule that a start is ignored while busy.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_NODATA = 2'd1,
        OP_SRST   = 2'd2,
        OP_ALT    = 2'd3
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [7:0]  command;
        logic [7:0]  device;
        logic [7:0]  feature;
        logic [15:0] count;
        logic [47:0] lba;
    } cmd_t;

    typedef struct packed {
        logic [3:0] addr;
        logic [7:0] data;
    } regwr_t;

    typedef enum logic [4:0] {
        S_IDLE, S_PRE, S_POLL_A, S_SRST_ON, S_SRST_HOLD, S_SRST_OFF, S_POST,
        S_CTL, S_RD_DEV, S_WR_DEV, S_SETTLE, S_PROG, S_POLL_B, S_BURST,
        S_CHK, S_DONE, S_FAIL
    } state_e;

    localparam logic [3:0] A_DATA = 4'h0;
    localparam logic [3:0] A_FEAT = 4'h1;
    localparam logic [3:0] A_CNT  = 4'h2;
    localparam logic [3:0] A_LO   = 4'h3;
    localparam logic [3:0] A_MID  = 4'h4;
    localparam logic [3:0] A_HI   = 4'h5;
    localparam logic [3:0] A_DEV  = 4'h6;
    localparam logic [3:0] A_STAT = 4'h7;
    localparam logic [3:0] A_DCTL = 4'hA;

    localparam logic [7:0] DCTL_RUN   = 8'h0A;
    localparam logic [7:0] DCTL_RESET = 8'h0E;

    localparam int BSY_BIT    = 7;
    localparam int DRQ_BIT    = 3;
    localparam int SEL_BIT    = 4;
    localparam int PROG_STEPS = 10;

    // Cycles for a wait given in microseconds, rounded up.
    function automatic int us_to_cycles(input int ticks_per_ms, input int us);
        return (ticks_per_ms * us + 999) / 1000;
    endfunction

endpackage

// File: rtl/ata_delay_cnt.sv
module ata_delay_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= value;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ata_prog_step.sv
module ata_prog_step
    import ata_pio_pkg::*;
(
    input  cmd_t       cmd,
    input  logic [3:0] step,
    output regwr_t     wr
);
    // Pairs go previous (high) byte first, current byte second.
    always_comb begin
        case (step)
            4'd0:    wr = '{addr: A_FEAT, data: cmd.feature};
            4'd1:    wr = '{addr: A_CNT,  data: cmd.count[15:8]};
            4'd2:    wr = '{addr: A_CNT,  data: cmd.count[7:0]};
            4'd3:    wr = '{addr: A_LO,   data: cmd.lba[31:24]};
            4'd4:    wr = '{addr: A_LO,   data: cmd.lba[7:0]};
            4'd5:    wr = '{addr: A_MID,  data: cmd.lba[39:32]};
            4'd6:    wr = '{addr: A_MID,  data: cmd.lba[15:8]};
            4'd7:    wr = '{addr: A_HI,   data: cmd.lba[47:40]};
            4'd8:    wr = '{addr: A_HI,   data: cmd.lba[23:16]};
            default: wr = '{addr: A_STAT, data: cmd.command};
        endcase
    end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int TICKS_PER_MS   = 50000,
    parameter int TIMEOUT_MS     = 32000,
    parameter int SETTLE_MS      = 50,
    parameter int PRE_RESET_MS   = 2,
    parameter int POST_RESET_MS  = 2,
    parameter int RESET_PULSE_US = 5,
    parameter int WORDS          = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [7:0]  command,
    input  logic [7:0]  device,
    input  logic [7:0]  feature,
    input  logic [15:0] count,
    input  logic [47:0] lba,
    output logic        busy,
    output logic        done,
    output logic        error,
    output logic [3:0]  bus_addr,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [7:0]  bus_wdata,
    input  logic [15:0] bus_rdata,
    output logic        word_valid,
    output logic [15:0] word_data
);
    localparam int TMO_CYC    = TICKS_PER_MS * TIMEOUT_MS;
    localparam int SETTLE_CYC = TICKS_PER_MS * SETTLE_MS;
    localparam int PRE_CYC    = TICKS_PER_MS * PRE_RESET_MS;
    localparam int POST_CYC   = TICKS_PER_MS * POST_RESET_MS;
    localparam int PULSE_CYC  = us_to_cycles(TICKS_PER_MS, RESET_PULSE_US);
    localparam int DLY_MAX    = (SETTLE_CYC > PRE_CYC)
                              ? ((SETTLE_CYC > POST_CYC) ? SETTLE_CYC : POST_CYC)
                              : ((PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC);
    localparam int DLY_W      = $clog2(DLY_MAX + PULSE_CYC + 1);
    localparam int TMO_W      = $clog2(TMO_CYC + 1);
    localparam int WCNT_W     = $clog2(WORDS);

    state_e             st, nxt;
    cmd_t               cmd_q;
    logic               old_sel;
    logic [3:0]         step;
    logic [WCNT_W-1:0]  wcnt;
    regwr_t             step_wr;
    logic               dly_load, dly_exp, tmo_load, tmo_exp;
    logic [DLY_W-1:0]   dly_val;
    logic               st_bsy, st_drq;

    ata_delay_cnt #(.W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .load(dly_load), .value(dly_val), .expired(dly_exp)
    );

    ata_delay_cnt #(.W(TMO_W)) u_tmo (
        .clk(clk), .rst(rst), .load(tmo_load), .value(TMO_W'(TMO_CYC)), .expired(tmo_exp)
    );

    ata_prog_step u_step (.cmd(cmd_q), .step(step), .wr(step_wr));

    assign st_bsy = bus_rdata[BSY_BIT];
    assign st_drq = bus_rdata[DRQ_BIT];

    always_comb begin
        nxt        = st;
        dly_load   = 1'b0;
        dly_val    = '0;
        tmo_load   = 1'b0;
        bus_addr   = A_STAT;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        bus_wdata  = '0;
        word_valid = 1'b0;
        case (st)
            S_IDLE: if (start) begin
                if (op_e'(op) == OP_SRST) begin
                    nxt = S_PRE; dly_load = 1'b1; dly_val = DLY_W'(PRE_CYC);
                end else begin
                    nxt = S_POLL_A; tmo_load = 1'b1;
                end
            end
            S_PRE: if (dly_exp) begin nxt = S_POLL_A; tmo_load = 1'b1; end
            S_POLL_A: begin
                bus_rd = 1'b1;
                if (!st_bsy)      nxt = (cmd_q.op == OP_SRST) ? S_SRST_ON : S_CTL;
                else if (tmo_exp) nxt = S_FAIL;
            end
            S_SRST_ON: begin
                bus_addr = A_DCTL; bus_wr = 1'b1; bus_wdata = DCTL_RESET;
                nxt = S_SRST_HOLD; dly_load = 1'b1; dly_val = DLY_W'(PULSE_CYC);
            end
            S_SRST_HOLD: if (dly_exp) nxt = S_SRST_OFF;
            S_SRST_OFF: begin
                bus_addr = A_DCTL; bus_wr = 1'b1; bus_wdata = DCTL_RUN;
                nxt = S_POST; dly_load = 1'b1; dly_val = DLY_W'(POST_CYC);
            end
            S_POST: if (dly_exp) begin nxt = S_POLL_B; tmo_load = 1'b1; end
            S_CTL: begin
                bus_addr = A_DCTL; bus_wr = 1'b1; bus_wdata = DCTL_RUN;
                nxt = S_RD_DEV;
            end
            S_RD_DEV: begin bus_addr = A_DEV; bus_rd = 1'b1; nxt = S_WR_DEV; end
            S_WR_DEV: begin
                bus_addr = A_DEV; bus_wr = 1'b1; bus_wdata = cmd_q.device;
                if (old_sel != cmd_q.device[SEL_BIT]) begin
                    nxt = S_SETTLE; dly_load = 1'b1; dly_val = DLY_W'(SETTLE_CYC);
                end else begin
                    nxt = S_PROG;
                end
            end
            S_SETTLE: if (dly_exp) nxt = S_PROG;
            S_PROG: begin
                bus_addr = step_wr.addr; bus_wr = 1'b1; bus_wdata = step_wr.data;
                if (step == 4'(PROG_STEPS - 1)) begin nxt = S_POLL_B; tmo_load = 1'b1; end
            end
            S_POLL_B: begin
                bus_rd = 1'b1;
                if (!st_bsy) begin
                    if (cmd_q.op == OP_READ) nxt = st_drq ? S_BURST : S_FAIL;
                    else                     nxt = S_DONE;
                end else if (tmo_exp) begin
                    nxt = S_FAIL;
                end
            end
            S_BURST: begin
                bus_addr = A_DATA; bus_rd = 1'b1; word_valid = 1'b1;
                if (wcnt == WCNT_W'(WORDS - 1)) nxt = S_CHK;
            end
            S_CHK: begin bus_rd = 1'b1; nxt = st_drq ? S_FAIL : S_DONE; end
            S_DONE:  nxt = S_IDLE;
            S_FAIL:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cmd_q   <= '0;
            old_sel <= 1'b0;
            step    <= '0;
            wcnt    <= '0;
        end else begin
            st <= nxt;
            if (st == S_IDLE && start)
                cmd_q <= '{op: op_e'(op), command: command, device: device,
                           feature: feature, count: count, lba: lba};
            if (st == S_RD_DEV) old_sel <= bus_rdata[SEL_BIT];
            step <= (st == S_PROG) ? step + 1'b1 : '0;
            wcnt <= (st == S_BURST) ? wcnt + 1'b1 : '0;
        end
    end

    assign busy      = (st != S_IDLE);
    assign done      = (st == S_DONE);
    assign error     = (st == S_FAIL);
    assign word_data = bus_rdata;
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk
    import ata_pio_pkg::*;
#(
    parameter int SETTLE_CYC = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic [3:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        word_valid
);
    logic     seen_sel;
    logic     pend;
    int       gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_sel <= 1'b0;
            pend     <= 1'b0;
            gap      <= 0;
        end else begin
            if (bus_rd && bus_addr == A_DEV) seen_sel <= bus_rdata[SEL_BIT];
            if (bus_wr) begin
                pend <= (bus_addr == A_DEV) && (bus_wdata[SEL_BIT] != seen_sel);
                gap  <= 0;
            end else if (gap < SETTLE_CYC + 2) begin
                gap <= gap + 1;
            end
        end
    end

    // R2
    pulse_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    // R2
    pulse_err_chk: assert property (@(posedge clk) disable iff (rst)
        error |=> (!error && !busy));
    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_wr && !bus_rd));
    // R4
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({bus_wr, bus_rd}) <= 1);
    // R5
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && pend) |-> (gap >= SETTLE_CYC));
    // R7
    word_read_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (bus_rd && bus_addr == A_DATA));
    // R10
    srst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DCTL && bus_wdata == DCTL_RESET) |=> !bus_wr);
endmodule

bind ata_pio_seq ata_pio_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .error(error),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .word_valid(word_valid)
);

// File: tb/tb_ata_pio_seq.sv
module tb_ata_pio_seq;
    localparam int TPM    = 4;
    localparam int TMO_MS = 500;
    localparam int TMO    = TPM * TMO_MS;
    localparam int SETTLE = TPM * 50;
    localparam int PRE    = TPM * 2;
    localparam int PULSE  = 1;
    localparam logic [15:0] SEED = 16'h5A3C;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  dev;
        logic [7:0]  prev;
        logic [7:0]  cmd;
        logic [7:0]  feat;
        logic [15:0] cnt;
        logic [47:0] lba;
        logic [1:0]  mode;     // 0 normal, 1 no data-request, 2 data-request stuck
        logic        exp_err;
        logic [8:0]  exp_words;
        logic        sw;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [0:NV-1] = '{
        '{op:2'd0, dev:8'hE0, prev:8'hE0, cmd:8'h20, feat:8'h00, cnt:16'h0001,
          lba:48'h0000_0012_3456, mode:2'd0, exp_err:1'b0, exp_words:9'd256, sw:1'b0},
        '{op:2'd0, dev:8'hF3, prev:8'hE0, cmd:8'h24, feat:8'h00, cnt:16'h0201,
          lba:48'hA1B2_C3D4_E5F6, mode:2'd0, exp_err:1'b0, exp_words:9'd256, sw:1'b1},
        '{op:2'd1, dev:8'hA0, prev:8'hB0, cmd:8'hEF, feat:8'h07, cnt:16'h0000,
          lba:48'h0000_0000_0000, mode:2'd0, exp_err:1'b0, exp_words:9'd0, sw:1'b1},
        '{op:2'd0, dev:8'hE0, prev:8'hE0, cmd:8'h20, feat:8'h00, cnt:16'h0001,
          lba:48'h0000_0000_0077, mode:2'd1, exp_err:1'b1, exp_words:9'd0, sw:1'b0},
        '{op:2'd0, dev:8'hB0, prev:8'hB0, cmd:8'hEC, feat:8'h00, cnt:16'h0000,
          lba:48'h0000_0000_0000, mode:2'd2, exp_err:1'b1, exp_words:9'd256, sw:1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [7:0]  command = '0, device = '0, feature = '0;
    logic [15:0] count = '0;
    logic [47:0] lba = '0;
    logic        busy, done, error, bus_wr, bus_rd, word_valid;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [15:0] bus_rdata, word_data;

    always #10 clk = ~clk;

    ata_pio_seq #(.TICKS_PER_MS(TPM), .TIMEOUT_MS(TMO_MS)) dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .command(command),
        .device(device), .feature(feature), .count(count), .lba(lba),
        .busy(busy), .done(done), .error(error), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .word_valid(word_valid), .word_data(word_data)
    );

    // Drive model configuration (written by tasks only)
    logic       m_clr = 1'b0;
    logic       m_force_bsy = 1'b0;
    logic [1:0] m_mode = '0;
    logic [1:0] m_op = '0;
    logic [7:0] m_init_dev = '0;

    // Drive model state and logs (written by the model block only)
    logic [7:0]  mreg [0:7];
    logic        m_bsy, m_drq;
    int          m_bcnt, m_words;
    logic [11:0] wlog [0:31];
    int          wcyc [0:31];
    int          wn, nwords, nbad, ndone, nerr, cyc, t_end;

    function automatic logic [15:0] exp_word(input int k);
        return SEED ^ {k[7:0], ~k[7:0]};
    endfunction

    always_comb begin
        case (bus_addr)
            4'h0:       bus_rdata = exp_word(m_words);
            4'h7, 4'hA: bus_rdata = {8'h00, (m_bsy | m_force_bsy), 1'b1, 2'b00, m_drq, 3'b000};
            default:    bus_rdata = {8'h00, mreg[bus_addr[2:0]]};
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (m_clr) begin
            for (int i = 0; i < 8; i++) mreg[i] <= 8'h00;
            mreg[6] <= m_init_dev;
            m_bsy <= 1'b0; m_drq <= 1'b0; m_bcnt <= 0; m_words <= 0;
            wn <= 0; nwords <= 0; nbad <= 0; ndone <= 0; nerr <= 0;
        end else begin
            if (bus_wr) begin
                if (!bus_addr[3]) mreg[bus_addr[2:0]] <= bus_wdata;
                if (wn < 32) begin
                    wlog[wn] <= {bus_addr, bus_wdata};
                    wcyc[wn] <= cyc;
                end
                wn <= wn + 1;
            end
            if (bus_wr && bus_addr == 4'h7) begin
                m_bsy <= 1'b1; m_bcnt <= 3;
            end else if (m_bsy) begin
                if (m_bcnt == 0) begin
                    m_bsy <= 1'b0;
                    m_drq <= (m_op == 2'd0) && (m_mode != 2'd1);
                end else begin
                    m_bcnt <= m_bcnt - 1;
                end
            end
            if (bus_rd && bus_addr == 4'h0) begin
                m_words <= m_words + 1;
                if (m_words == 255) m_drq <= (m_mode == 2'd2);
            end
            if (word_valid) begin
                if (word_data != exp_word(nwords)) nbad <= nbad + 1;
                nwords <= nwords + 1;
            end
            if (done)  begin ndone <= ndone + 1; t_end <= cyc; end
            if (error) begin nerr  <= nerr + 1;  t_end <= cyc; end
        end
    end

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int t_start;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset(input logic [1:0] mode, input logic [1:0] mop, input logic [7:0] idev);
        @(negedge clk);
        m_mode = mode; m_op = mop; m_init_dev = idev; m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0;
    endtask

    task automatic pulse_start(input logic [1:0] o, input vec_t v);
        @(negedge clk);
        op = o; command = v.cmd; device = v.dev; feature = v.feat; count = v.cnt; lba = v.lba;
        start = 1'b1; t_start = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (ndone + nerr != 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [11:0] exp_wr(input vec_t v, input int i);
        case (i)
            0:  return {4'hA, 8'h0A};
            1:  return {4'h6, v.dev};
            2:  return {4'h1, v.feat};
            3:  return {4'h2, v.cnt[15:8]};
            4:  return {4'h2, v.cnt[7:0]};
            5:  return {4'h3, v.lba[31:24]};
            6:  return {4'h3, v.lba[7:0]};
            7:  return {4'h4, v.lba[39:32]};
            8:  return {4'h4, v.lba[15:8]};
            9:  return {4'h5, v.lba[47:40]};
            10: return {4'h5, v.lba[23:16]};
            default: return {4'h7, v.cmd};
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc = 0;
        model_reset(2'd0, 2'd0, 8'h00);
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, done, error, bus_wr, bus_rd, word_valid} == 6'b0, "R1 reset outputs",
              {busy, done, error, bus_wr, bus_rd, word_valid}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy, "R1 idle after reset", busy, 0);

        // Table of command vectors
        for (int n = 0; n < NV; n++) begin
            vec_t v;
            string tag;
            int bad;
            v = VEC[n];
            tag = (v.mode == 2'd1) ? "R6" : (v.mode == 2'd2) ? "R8" : (v.op == 2'd1) ? "R9" : "R7";
            model_reset(v.mode, v.op, v.prev);
            pulse_start(v.op, v);
            wait_end();
            check(nerr == int'(v.exp_err) && ndone == int'(!v.exp_err),
                  $sformatf("%s outcome vec%0d", tag, n), {ndone, nerr}, {32'(!v.exp_err), 32'(v.exp_err)});
            check(wn == 12, $sformatf("R4 write count vec%0d", n), wn, 12);
            bad = 0;
            for (int i = 0; i < 12; i++) if (wlog[i] != exp_wr(v, i)) bad++;
            check(bad == 0, $sformatf("R4 write order vec%0d", n), wlog[2], exp_wr(v, 2));
            if (v.sw)
                check(wcyc[2] - wcyc[1] >= SETTLE, $sformatf("R5 settle vec%0d", n), wcyc[2] - wcyc[1], SETTLE);
            else
                check(wcyc[2] - wcyc[1] == 1, $sformatf("R5 no settle vec%0d", n), wcyc[2] - wcyc[1], 1);
            check(nwords == int'(v.exp_words) && nbad == 0, $sformatf("%s words vec%0d", tag, n),
                  nwords, v.exp_words);
            check(!busy, $sformatf("R2 idle after vec%0d", n), busy, 0);
        end

        // R3: busy never clears -> timeout, no writes
        model_reset(2'd0, 2'd0, 8'hE0);
        m_force_bsy = 1'b1;
        pulse_start(2'd0, VEC[0]);
        wait_end();
        check(nerr == 1 && ndone == 0, "R3 timeout error", nerr, 1);
        check(wn == 0, "R3 no writes while busy", wn, 0);
        check(t_end - t_start >= TMO, "R3 timeout length", t_end - t_start, TMO);
        m_force_bsy = 1'b0;

        // R10: soft reset sequence
        model_reset(2'd0, 2'd2, 8'hE0);
        pulse_start(2'd2, VEC[0]);
        wait_end();
        check(ndone == 1 && nerr == 0, "R10 done", ndone, 1);
        check(wn == 2, "R10 write count", wn, 2);
        check(wlog[0] == {4'hA, 8'h0E} && wlog[1] == {4'hA, 8'h0A}, "R10 values",
              {wlog[0], wlog[1]}, {12'hA0E, 12'hA0A});
        check(wcyc[0] - t_start >= PRE, "R10 pre wait", wcyc[0] - t_start, PRE);
        check(wcyc[1] - wcyc[0] > PULSE, "R10 pulse hold", wcyc[1] - wcyc[0], PULSE + 1);

        // R2: start during a burst is ignored
        model_reset(2'd0, 2'd0, 8'hE0);
        pulse_start(2'd0, VEC[0]);
        repeat (30) @(negedge clk);
        check(busy, "R2 busy mid burst", busy, 1);
        pulse_start(2'd2, VEC[2]);
        wait_end();
        repeat (40) @(negedge clk);
        check(ndone == 1 && nerr == 0, "R2 single outcome", ndone, 1);
        check(wn == 12 && wlog[11] == {4'h7, 8'h20}, "R2 no extra writes", wn, 12);
        check(!busy && nwords == 256, "R2 late start not run", nwords, 256);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule